// File: doc/BRIEF.md
# Fault Entry and Return Sequencer

This block owns the machine-control state of a small 32-bit processor and performs the state changes for taking a fault and for returning from one. It holds three registers: the live control word, one saved control word beneath it, and the fault return address. Together, the live and saved words act as a two-deep stack. Taking a fault pushes the live word down into the saved slot and builds a fresh supervisor-mode word. Returning pops the saved word back into the live slot and sends fetch to the stored return address.

The pipeline presents several things to the block: an already encoded fault request, a return request, the current program counter with a fetch-valid flag, and supervisor-only writes to the saved word and the return address. The block answers one clock later with a registered next program counter and a one-cycle redirect strobe. Its other outputs are the current mode, the interrupt-disable bit and the full live control word.

Control word fields, by bit position:
- MODE[1:0]: 2'b10 is supervisor and 2'b00 is user.
- ID[2]: interrupt disable.
- CAUSE[11:4]: the fault code.
- COMMENT[19:12]: the note supplied with a user-generated fault.

Top module: `fault_sequencer`

## Requirements
- R1: While `rst` is high, the block goes to its reset state at the clock edge. In that state the control word is 32'h0000_0006 (supervisor mode with ID set), the saved word and the return address are zero, `pc_next` is zero and `redirect` is low.
- R2: An accepted fault entry has these effects:
  - the saved word takes the previous control word;
  - the control word is cleared and then receives MODE=2'b10, ID=1 and CAUSE[11:4] equal to the cause;
  - all other control-word bits read zero.
- R3: When `flt_user` is high, a fault request writes `flt_note` into COMMENT[19:12]. Every other fault entry leaves COMMENT at zero.
- R4: On an external fault, the return address captures `pc_in` + 4 when `flt_next` is 1 and `pc_in` otherwise. One cycle after any fault entry, `pc_next` is 0 and `redirect` is high.
- R5: A return request makes these changes:
  - the control word becomes the saved word;
  - the saved word becomes zero;
  - one cycle later, `pc_next` equals the stored return address and `redirect` is high.
- R6: A fault request in the same cycle as a return request wins: the fault is entered and the return is dropped.
- R7: With no external fault, `fetch_vld` high and `pc_in[1:0]` not 2'b00 cause a fault entry with CAUSE 8'h01. The return address for this fault is `pc_in`.
- R8: In supervisor mode, with no fault and no return in that cycle, two writes take effect:
  - `sv_wr_saved` loads `sv_wdata` into the saved word;
  - `sv_wr_ret` loads `sv_wdata` into the return address.

  Neither write redirects. A write in the same cycle as a return is ignored.
- R9: Outside supervisor mode, a write request changes neither the saved word nor the return address. Instead it enters a fault with CAUSE 8'h02, and the return address is `pc_in`. An external fault or a misaligned fetch in the same cycle takes precedence.
- R10: `redirect` is high only in the cycle after an accepted fault entry or return, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_req | input | 1 | External fault request |
| flt_cause | input | 8 | Encoded fault cause |
| flt_next | input | 1 | Return address select: 1 = pc_in + 4, 0 = pc_in |
| flt_user | input | 1 | Fault is user-generated; record flt_note |
| flt_note | input | 8 | Comment value for a user-generated fault |
| ret_req | input | 1 | Return-from-fault request |
| fetch_vld | input | 1 | pc_in is a live fetch address, checked for alignment |
| pc_in | input | 32 | Current program counter |
| sv_wr_saved | input | 1 | Supervisor write of the saved control word |
| sv_wr_ret | input | 1 | Supervisor write of the return address |
| sv_wdata | input | 32 | Data for supervisor writes |
| pc_next | output | 32 | Redirect target program counter |
| redirect | output | 1 | One-cycle strobe marking a new pc_next |
| mode | output | 2 | Current MODE field |
| irq_dis | output | 1 | Current interrupt-disable bit |
| ctrl_word | output | 32 | Live control word |

## Verification
The embedded properties check the following on every cycle:
- the push and pop of the two-level stack;
- the supervisor/ID forcing and the zeroed COMMENT on non-user faults;
- the trap vector and the return-address capture;
- the jump back to the stored address and the absence of `redirect` in idle or write cycles;
- the priority of faults over returns and the mapping of misaligned fetches and user-mode writes to their fixed causes.

Some behaviour is visible only through the bench's scenarios, because it spans several operations and shows up only on a later return:
- the full sweep of all 256 cause codes with both return-address selections;
- nested entry followed by an unwind to user mode;
- the evidence that an ignored write did not disturb the return address or the saved word.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int MODE_LSB  = 0;
  localparam int MODE_W    = 2;
  localparam int ID_BIT    = 2;
  localparam int CAUSE_LSB = 4;
  localparam int CAUSE_W   = 8;
  localparam int NOTE_LSB  = 12;
  localparam int NOTE_W    = 8;

  localparam logic [MODE_W-1:0]  MODE_SUP = 2'b10;
  localparam logic [MODE_W-1:0]  MODE_USR = 2'b00;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 8'h01;
  localparam logic [CAUSE_W-1:0] CAUSE_PRIV     = 8'h02;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_ENTER = 2'd1,
    ACT_LEAVE = 2'd2,
    ACT_WRITE = 2'd3
  } act_e;
endpackage

// File: rtl/trap_decide.sv
module trap_decide
  import trap_pkg::*;
(
  input  logic               flt_req,
  input  logic [CAUSE_W-1:0] flt_cause,
  input  logic               flt_next,
  input  logic               flt_user,
  input  logic               ret_req,
  input  logic               fetch_vld,
  input  logic [1:0]         pc_lo,
  input  logic               wr_saved,
  input  logic               wr_ret,
  input  logic               in_sup,
  output act_e               act_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               note_en_o,
  output logic               use_next_o
);
  logic misalign;
  logic priv_bad;

  assign misalign = fetch_vld & (pc_lo != 2'b00);
  assign priv_bad = (wr_saved | wr_ret) & ~in_sup;

  always_comb begin
    act_o      = ACT_IDLE;
    cause_o    = '0;
    note_en_o  = 1'b0;
    use_next_o = 1'b0;
    if (flt_req) begin
      act_o      = ACT_ENTER;
      cause_o    = flt_cause;
      note_en_o  = flt_user;
      use_next_o = flt_next;
    end else if (misalign) begin
      act_o   = ACT_ENTER;
      cause_o = CAUSE_MISALIGN;
    end else if (priv_bad) begin
      act_o   = ACT_ENTER;
      cause_o = CAUSE_PRIV;
    end else if (ret_req) begin
      act_o = ACT_LEAVE;
    end else if (wr_saved | wr_ret) begin
      act_o = ACT_WRITE;
    end
  end
endmodule

// File: rtl/ctrl_stack.sv
module ctrl_stack
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  act_e               act,
  input  logic [CAUSE_W-1:0] cause,
  input  logic               note_en,
  input  logic [NOTE_W-1:0]  note,
  input  logic               wr_saved,
  input  logic [XLEN-1:0]    wdata,
  output logic [XLEN-1:0]    mcr_o
);
  localparam logic [XLEN-1:0] BOOT_WORD =
    XLEN'(MODE_SUP) << MODE_LSB | XLEN'(1) << ID_BIT;

  logic [XLEN-1:0] saved_q;
  logic [XLEN-1:0] entry_word;

  always_comb begin
    entry_word = '0;
    entry_word[MODE_LSB +: MODE_W]   = MODE_SUP;
    entry_word[ID_BIT]               = 1'b1;
    entry_word[CAUSE_LSB +: CAUSE_W] = cause;
    if (note_en) entry_word[NOTE_LSB +: NOTE_W] = note;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcr_o   <= BOOT_WORD;
      saved_q <= '0;
    end else begin
      case (act)
        ACT_ENTER: begin
          saved_q <= mcr_o;
          mcr_o   <= entry_word;
        end
        ACT_LEAVE: begin
          mcr_o   <= saved_q;
          saved_q <= '0;
        end
        ACT_WRITE: if (wr_saved) saved_q <= wdata;
        default: ;
      endcase
    end
  end

  assert_push_R2: assert property (@(posedge clk) disable iff (rst)
    act == ACT_ENTER |=> saved_q == $past(mcr_o) &&
      mcr_o[MODE_LSB +: MODE_W] == MODE_SUP && mcr_o[ID_BIT]);
  assert_note_zero_R3: assert property (@(posedge clk) disable iff (rst)
    act == ACT_ENTER && !note_en |=> mcr_o[NOTE_LSB +: NOTE_W] == '0);
  assert_pop_R5: assert property (@(posedge clk) disable iff (rst)
    act == ACT_LEAVE |=> mcr_o == $past(saved_q) && saved_q == '0);
endmodule

// File: rtl/ret_unit.sv
module ret_unit
  import trap_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] TRAP_VEC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  act_e            act,
  input  logic            use_next,
  input  logic [XLEN-1:0] pc_in,
  input  logic            wr_ret,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] pc_next_o,
  output logic            redirect_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] fret_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fret_q     <= '0;
      pc_next_o  <= '0;
      redirect_o <= 1'b0;
    end else begin
      redirect_o <= 1'b0;
      case (act)
        ACT_ENTER: begin
          fret_q     <= use_next ? pc_in + STEP : pc_in;
          pc_next_o  <= TRAP_VEC;
          redirect_o <= 1'b1;
        end
        ACT_LEAVE: begin
          pc_next_o  <= fret_q;
          redirect_o <= 1'b1;
        end
        ACT_WRITE: if (wr_ret) fret_q <= wdata;
        default: ;
      endcase
    end
  end

  assert_vector_R4: assert property (@(posedge clk) disable iff (rst)
    act == ACT_ENTER |=> redirect_o && pc_next_o == TRAP_VEC);
  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    act == ACT_ENTER |=>
      fret_q == ($past(use_next) ? $past(pc_in) + STEP : $past(pc_in)));
  assert_jump_back_R5: assert property (@(posedge clk) disable iff (rst)
    act == ACT_LEAVE |=> redirect_o && pc_next_o == $past(fret_q));
  assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_IDLE || act == ACT_WRITE) |=> !redirect_o);
endmodule

// File: rtl/fault_sequencer.sv
module fault_sequencer
  import trap_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] TRAP_VEC = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flt_req,
  input  logic [CAUSE_W-1:0] flt_cause,
  input  logic               flt_next,
  input  logic               flt_user,
  input  logic [NOTE_W-1:0]  flt_note,
  input  logic               ret_req,
  input  logic               fetch_vld,
  input  logic [XLEN-1:0]    pc_in,
  input  logic               sv_wr_saved,
  input  logic               sv_wr_ret,
  input  logic [XLEN-1:0]    sv_wdata,
  output logic [XLEN-1:0]    pc_next,
  output logic               redirect,
  output logic [MODE_W-1:0]  mode,
  output logic               irq_dis,
  output logic [XLEN-1:0]    ctrl_word
);
  act_e               act;
  logic [CAUSE_W-1:0] cause;
  logic               note_en;
  logic               use_next;
  logic               in_sup;

  assign in_sup    = ctrl_word[MODE_LSB +: MODE_W] == MODE_SUP;
  assign mode      = ctrl_word[MODE_LSB +: MODE_W];
  assign irq_dis   = ctrl_word[ID_BIT];

  trap_decide u_decide (
    .flt_req    (flt_req),
    .flt_cause  (flt_cause),
    .flt_next   (flt_next),
    .flt_user   (flt_user),
    .ret_req    (ret_req),
    .fetch_vld  (fetch_vld),
    .pc_lo      (pc_in[1:0]),
    .wr_saved   (sv_wr_saved),
    .wr_ret     (sv_wr_ret),
    .in_sup     (in_sup),
    .act_o      (act),
    .cause_o    (cause),
    .note_en_o  (note_en),
    .use_next_o (use_next)
  );

  ctrl_stack #(.XLEN(XLEN)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .cause    (cause),
    .note_en  (note_en),
    .note     (flt_note),
    .wr_saved (sv_wr_saved),
    .wdata    (sv_wdata),
    .mcr_o    (ctrl_word)
  );

  ret_unit #(.XLEN(XLEN), .TRAP_VEC(TRAP_VEC)) u_ret (
    .clk        (clk),
    .rst        (rst),
    .act        (act),
    .use_next   (use_next),
    .pc_in      (pc_in),
    .wr_ret     (sv_wr_ret),
    .wdata      (sv_wdata),
    .pc_next_o  (pc_next),
    .redirect_o (redirect)
  );

  assert_fault_wins_R6: assert property (@(posedge clk) disable iff (rst)
    flt_req && ret_req |=> redirect && pc_next == TRAP_VEC &&
      ctrl_word[CAUSE_LSB +: CAUSE_W] == $past(flt_cause));
  assert_misalign_R7: assert property (@(posedge clk) disable iff (rst)
    !flt_req && fetch_vld && pc_in[1:0] != 2'b00 |=>
      ctrl_word[CAUSE_LSB +: CAUSE_W] == CAUSE_MISALIGN);
  assert_user_write_R9: assert property (@(posedge clk) disable iff (rst)
    !flt_req && !(fetch_vld && pc_in[1:0] != 2'b00) &&
    (sv_wr_saved || sv_wr_ret) && mode != MODE_SUP |=>
      ctrl_word[CAUSE_LSB +: CAUSE_W] == CAUSE_PRIV && mode == MODE_SUP);
endmodule

// File: tb/fault_sequencer_test.sv
module fault_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        flt_req, flt_next, flt_user, ret_req, fetch_vld;
  logic        sv_wr_saved, sv_wr_ret;
  logic [7:0]  flt_cause, flt_note;
  logic [31:0] pc_in, sv_wdata;
  logic [31:0] pc_next, ctrl_word;
  logic        redirect, irq_dis;
  logic [1:0]  mode;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_mcr, m_saved, m_fret, m_pc;
  logic        m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_sequencer uut (
    .clk(clk), .rst(rst), .flt_req(flt_req), .flt_cause(flt_cause),
    .flt_next(flt_next), .flt_user(flt_user), .flt_note(flt_note),
    .ret_req(ret_req), .fetch_vld(fetch_vld), .pc_in(pc_in),
    .sv_wr_saved(sv_wr_saved), .sv_wr_ret(sv_wr_ret), .sv_wdata(sv_wdata),
    .pc_next(pc_next), .redirect(redirect), .mode(mode),
    .irq_dis(irq_dis), .ctrl_word(ctrl_word)
  );

  task automatic idle();
    flt_req = 0; flt_next = 0; flt_user = 0; ret_req = 0; fetch_vld = 0;
    sv_wr_saved = 0; sv_wr_ret = 0; flt_cause = 0; flt_note = 0;
    pc_in = 0; sv_wdata = 0;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (pc_next !== m_pc || redirect !== m_rd || ctrl_word !== m_mcr ||
        mode !== m_mcr[1:0] || irq_dis !== m_mcr[2]) begin
      errors++;
      $display("FAIL %s: got pc=%h rd=%b cw=%h mode=%b id=%b exp pc=%h rd=%b cw=%h",
               tag, pc_next, redirect, ctrl_word, mode, irq_dis, m_pc, m_rd, m_mcr);
    end
  endtask

  // Apply the inputs already driven, update the model from the requirements, compare.
  task automatic step(input string tag);
    logic mis, prv, ent;
    logic [7:0] c;
    @(posedge clk);
    mis = fetch_vld && pc_in[1:0] != 2'b00;
    prv = (sv_wr_saved || sv_wr_ret) && m_mcr[1:0] != 2'b10;
    ent = flt_req || mis || prv;
    if (ent) begin
      c = flt_req ? flt_cause : (mis ? 8'h01 : 8'h02);
      m_saved = m_mcr;
      m_mcr = 32'h6 | (32'(c) << 4) | ((flt_req && flt_user) ? 32'(flt_note) << 12 : 32'h0);
      m_fret = (flt_req && flt_next) ? pc_in + 32'd4 : pc_in;
      m_pc = 32'h0;
      m_rd = 1'b1;
    end else if (ret_req) begin
      m_mcr = m_saved;
      m_saved = 32'h0;
      m_pc = m_fret;
      m_rd = 1'b1;
    end else begin
      m_rd = 1'b0;
      if (sv_wr_saved) m_saved = sv_wdata;
      if (sv_wr_ret)   m_fret  = sv_wdata;
    end
    @(negedge clk);
    compare(tag);
    idle();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_mcr = 32'h6; m_saved = 0; m_fret = 0; m_pc = 0; m_rd = 0;
    compare("R1 reset");

    // R2 R3 R4 R5: every cause code, both return selects, with and without note
    for (int c = 0; c < 256; c++) begin
      flt_req = 1; flt_cause = 8'(c); flt_next = c[0]; flt_user = c[1];
      flt_note = ~8'(c); pc_in = 32'(c) << 4; fetch_vld = c[2];
      step(c[1] ? "R3 user fault" : "R2 R4 fault entry");
      ret_req = 1;
      step("R5 return");
    end

    // R8: supervisor writes, no redirect
    sv_wr_saved = 1; sv_wdata = 32'h0;
    step("R8 write saved");
    sv_wr_ret = 1; sv_wdata = 32'h200;
    step("R8 write fret");
    ret_req = 1;
    step("R5 return to user");

    // R9: write from user mode is refused and traps
    sv_wr_ret = 1; sv_wdata = 32'hDEAD_BEE0; pc_in = 32'h204;
    step("R9 user write traps");
    ret_req = 1;
    step("R9 fret kept pc");
    sv_wr_saved = 1; sv_wdata = 32'h0000_0ABC; pc_in = 32'h208;
    step("R9 user saved write traps");
    ret_req = 1;
    step("R9 saved word unchanged");

    // R7: misaligned fetches, then an aligned one
    for (int lo = 1; lo < 4; lo++) begin
      fetch_vld = 1; pc_in = 32'h300 | 32'(lo);
      step("R7 misaligned");
      ret_req = 1;
      step("R7 return");
    end
    fetch_vld = 1; pc_in = 32'h300;
    step("R10 aligned fetch quiet");

    // R6: fault beats return
    flt_req = 1; flt_cause = 8'h5A; ret_req = 1; pc_in = 32'h400; flt_next = 1;
    step("R6 fault over return");
    ret_req = 1;
    step("R6 return after");

    // R8: write alongside return is ignored
    flt_req = 1; flt_cause = 8'h03; pc_in = 32'h10;
    step("R2 enter supervisor");
    ret_req = 1; sv_wr_ret = 1; sv_wdata = 32'h7770;
    step("R8 return with write");
    ret_req = 1;
    step("R8 write ignored");

    // R2 R5: nested entry and unwind
    flt_req = 1; flt_cause = 8'h07; pc_in = 32'h20; flt_next = 1;
    step("R2 first fault");
    flt_req = 1; flt_cause = 8'h08; pc_in = 32'h30; flt_user = 1; flt_note = 8'hC3;
    step("R3 nested fault");
    ret_req = 1;
    step("R5 first unwind");
    ret_req = 1;
    step("R5 second unwind");

    repeat (3) step("R10 idle");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule